// File: doc/BRIEF.md
# Alarm, Timer and Periodic Interrupt Unit

This block produces the interrupt request of a real-time clock. It is fed by the timekeeping logic: a one-cycle tick that marks each 10 ms step, and the current time fields (hundredths, seconds, minutes, hours, day of month). From these it derives three interrupt sources. The first is a periodic event whose interval can be 10 ms, 100 ms, 1 s or 1 min. The second is an alarm that fires when the current time matches a stored setting. That setting covers fields up to the day of the month, and any field can be marked don't-care so the alarm repeats. The third is an elapsed-time timer that counts up to 23:59:59.99, halts there and raises a terminal event.

Each source has a sticky status flag and an enable bit. Software clears a flag by writing a one to its clear bit. The request line is active low and open drain: the `irq_n` output is 0 when the pad must pull low, and 1 when the pad is released to the external pull-up. In standby only the alarm source can pull the line low. The other flags still record their events.

Top module: `rtc_irq_unit`

## Requirements
- R1: After synchronous reset, `flags` is 0, `tmr_value` is 0 and `irq_n` is 1.
- R2: Let N be the number of `tick` pulses since reset. A periodic event sets flag bit 0 on the tick where N is a multiple of P. P is 1, 10, 100 or 6000 for `per_rate` values 0, 1, 2 and 3 respectively.
- R3: An alarm event sets flag bit 1 on a cycle where all of these hold: `tick` is 1, `cur_hsec` is 0, and every compared field equals its alarm field. The fields are seconds, minutes, hours and day. A field is left out of the comparison when its `alm_ignore` bit is 1 (bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day).
- R4: A flag stays set until a cycle in which its `flag_clear` bit is 1, and it is then 0 on the next cycle. An event in the same cycle as the clear wins, and the flag stays 1.
- R5: Outside standby, `irq_n` is 0 exactly when some bit of `flags & src_enable` is 1. It follows the flags in the same cycle they change.
- R6: While `standby` is 1, only flag bit 1 combined with `src_enable[1]` can drive `irq_n` to 0. Flag bits 0 and 2 are still set by their events.
- R7: The timer value is packed as {hour[4:0], min[5:0], sec[5:0], hsec[6:0]}. With `tmr_run` at 1, each tick advances it by 0.01 s, carrying at 100 hundredths, 60 seconds and 60 minutes.
- R8: On the tick where counting brings the timer to 23:59:59.99, flag bit 2 is set. After that, further ticks leave the value unchanged.
- R9: `tmr_clear` zeroes the timer and takes priority over `tmr_load`. `tmr_load` copies `tmr_load_val` into the timer. Both take priority over counting, and neither sets flag bit 2.
- R10: With `tmr_run` at 0 and no clear or load, the timer value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per 10 ms step |
| per_rate | input | 2 | Periodic interval: 0=10 ms, 1=100 ms, 2=1 s, 3=1 min |
| cur_hsec | input | 7 | Current hundredths of a second |
| cur_sec | input | 6 | Current seconds |
| cur_min | input | 6 | Current minutes |
| cur_hour | input | 5 | Current hours (0-23) |
| cur_day | input | 5 | Current day of month |
| alm_sec | input | 6 | Alarm seconds |
| alm_min | input | 6 | Alarm minutes |
| alm_hour | input | 5 | Alarm hours |
| alm_day | input | 5 | Alarm day of month |
| alm_ignore | input | 4 | Don't-care mask for the alarm fields |
| tmr_run | input | 1 | Timer counts on ticks when 1 |
| tmr_clear | input | 1 | Zero the timer |
| tmr_load | input | 1 | Preset the timer from `tmr_load_val` |
| tmr_load_val | input | 24 | Preset value, packed as in R7 |
| src_enable | input | 3 | Enable per source: bit 0 periodic, bit 1 alarm, bit 2 timer |
| flag_clear | input | 3 | Write-one-to-clear strobe per flag |
| standby | input | 1 | Standby: only the alarm reaches the line |
| flags | output | 3 | Pending flags, bit order as `src_enable` |
| tmr_value | output | 24 | Elapsed time, packed as in R7 |
| irq_n | output | 1 | 0 = pull the open-drain line low, 1 = release |

## Verification
A prescaler stage that slips shows up at the ports as a periodic flag that rises on the wrong tick. At the 10 ms and 100 ms rates this appears within ten ticks; at the minute rate it can take up to 6000 ticks. A wrong carry in the timer appears in `tmr_value` on the first tick that crosses the faulty boundary. The bench checks every cycle, so such an error is reported in the cycle it occurs. A flag that leaks or clears early, or a standby gate set to the wrong source, shows up on `irq_n` one cycle after the disturbing event or clear strobe.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int HS_W = 7;
    localparam int SC_W = 6;
    localparam int MN_W = 6;
    localparam int HR_W = 5;
    localparam int DY_W = 5;

    localparam int NSRC    = 3;
    localparam int SRC_PER = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_TMR = 2;

    localparam int ALM_FIELDS = 4;

    localparam int HS_TOP = 99;
    localparam int SC_TOP = 59;
    localparam int MN_TOP = 59;
    localparam int HR_TOP = 23;

    typedef enum logic [1:0] {
        RATE_10MS  = 2'd0,
        RATE_100MS = 2'd1,
        RATE_1S    = 2'd2,
        RATE_1MIN  = 2'd3
    } rate_e;

    typedef struct packed {
        logic [HR_W-1:0] hour;
        logic [MN_W-1:0] min;
        logic [SC_W-1:0] sec;
        logic [HS_W-1:0] hsec;
    } span_t;

    localparam int SPAN_W = $bits(span_t);

    typedef struct packed {
        logic [DY_W-1:0] day;
        logic [HR_W-1:0] hour;
        logic [MN_W-1:0] min;
        logic [SC_W-1:0] sec;
    } stamp_t;

    function automatic logic span_at_end(span_t t);
        return (t.hour == HR_W'(HR_TOP)) && (t.min == MN_W'(MN_TOP)) &&
               (t.sec == SC_W'(SC_TOP)) && (t.hsec == HS_W'(HS_TOP));
    endfunction

    function automatic span_t span_step(span_t t);
        span_t n;
        n = t;
        if (t.hsec != HS_W'(HS_TOP)) begin
            n.hsec = t.hsec + 1'b1;
        end else begin
            n.hsec = '0;
            if (t.sec != SC_W'(SC_TOP)) begin
                n.sec = t.sec + 1'b1;
            end else begin
                n.sec = '0;
                if (t.min != MN_W'(MN_TOP)) begin
                    n.min = t.min + 1'b1;
                end else begin
                    n.min  = '0;
                    n.hour = t.hour + 1'b1;
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/irq_rate_gen.sv
module irq_rate_gen
    import rtc_irq_pkg::*;
#(
    parameter int DIV_SUB = 10,
    parameter int DIV_SEC = 10,
    parameter int DIV_MIN = 60
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  rate_e rate,
    output logic  ev
);

    localparam int NST  = 3;
    localparam int DMAX = (DIV_MIN > DIV_SUB) ? ((DIV_MIN > DIV_SEC) ? DIV_MIN : DIV_SEC)
                                              : ((DIV_SUB > DIV_SEC) ? DIV_SUB : DIV_SEC);
    localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;

    function automatic int div_of(int i);
        case (i)
            0:       return DIV_SUB;
            1:       return DIV_SEC;
            default: return DIV_MIN;
        endcase
    endfunction

    logic [NST-1:0] wrap;
    logic [NST:0]   pulse;

    always_comb begin
        pulse[0] = tick;
        for (int k = 1; k <= NST; k++) begin
            pulse[k] = pulse[k-1] & wrap[k-1];
        end
    end

    for (genvar g = 0; g < NST; g++) begin : g_stage
        localparam int D = div_of(g);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= '0;
            end else if (pulse[g]) begin
                cnt <= (cnt == CW'(D - 1)) ? '0 : cnt + 1'b1;
            end
        end

        assign wrap[g] = (cnt == CW'(D - 1));
    end

    assign ev = pulse[rate];

endmodule

// File: rtl/irq_alarm_match.sv
module irq_alarm_match
    import rtc_irq_pkg::*;
(
    input  logic                  tick,
    input  logic [HS_W-1:0]       now_hsec,
    input  stamp_t                now,
    input  stamp_t                target,
    input  logic [ALM_FIELDS-1:0] ignore,
    output logic                  ev
);

    logic [ALM_FIELDS-1:0] hit;

    always_comb begin
        hit[0] = ignore[0] || (now.sec  == target.sec);
        hit[1] = ignore[1] || (now.min  == target.min);
        hit[2] = ignore[2] || (now.hour == target.hour);
        hit[3] = ignore[3] || (now.day  == target.day);
    end

    assign ev = tick && (now_hsec == '0) && (&hit);

endmodule

// File: rtl/irq_elapsed_timer.sv
module irq_elapsed_timer
    import rtc_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  run,
    input  logic  clear,
    input  logic  load,
    input  span_t load_val,
    output span_t value,
    output logic  end_ev
);

    span_t cur_q;
    span_t next_c;
    logic  count_c;

    assign count_c = run && tick && !clear && !load && !span_at_end(cur_q);
    assign next_c  = span_step(cur_q);
    assign end_ev  = count_c && span_at_end(next_c);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= load_val;
        end else if (count_c) begin
            cur_q <= next_c;
        end
    end

    assign value = cur_q;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic f_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                f_q <= 1'b0;
            end else begin
                f_q <= set[g] | (f_q & ~clr[g]);
            end
        end

        assign pend[g] = f_q;
    end

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int DIV_SUB = 10,
    parameter int DIV_SEC = 10,
    parameter int DIV_MIN = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [1:0]  per_rate,
    input  logic [6:0]  cur_hsec,
    input  logic [5:0]  cur_sec,
    input  logic [5:0]  cur_min,
    input  logic [4:0]  cur_hour,
    input  logic [4:0]  cur_day,
    input  logic [5:0]  alm_sec,
    input  logic [5:0]  alm_min,
    input  logic [4:0]  alm_hour,
    input  logic [4:0]  alm_day,
    input  logic [3:0]  alm_ignore,
    input  logic        tmr_run,
    input  logic        tmr_clear,
    input  logic        tmr_load,
    input  logic [23:0] tmr_load_val,
    input  logic [2:0]  src_enable,
    input  logic [2:0]  flag_clear,
    input  logic        standby,
    output logic [2:0]  flags,
    output logic [23:0] tmr_value,
    output logic        irq_n
);

    stamp_t           now_s;
    stamp_t           tgt_s;
    span_t            ld_s;
    span_t            tv_s;
    logic [NSRC-1:0]  ev;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  reach;

    assign now_s = '{day: cur_day, hour: cur_hour, min: cur_min, sec: cur_sec};
    assign tgt_s = '{day: alm_day, hour: alm_hour, min: alm_min, sec: alm_sec};
    assign ld_s  = span_t'(tmr_load_val);

    irq_rate_gen #(
        .DIV_SUB (DIV_SUB),
        .DIV_SEC (DIV_SEC),
        .DIV_MIN (DIV_MIN)
    ) rate_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .rate (rate_e'(per_rate)),
        .ev   (ev[SRC_PER])
    );

    irq_alarm_match alarm_i (
        .tick     (tick),
        .now_hsec (cur_hsec),
        .now      (now_s),
        .target   (tgt_s),
        .ignore   (alm_ignore),
        .ev       (ev[SRC_ALM])
    );

    irq_elapsed_timer timer_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (tmr_run),
        .clear    (tmr_clear),
        .load     (tmr_load),
        .load_val (ld_s),
        .value    (tv_s),
        .end_ev   (ev[SRC_TMR])
    );

    irq_flag_bank #(.N(NSRC)) flags_i (
        .clk  (clk),
        .rst  (rst),
        .set  (ev),
        .clr  (flag_clear),
        .pend (pend)
    );

    // In standby only the alarm source may reach the request line.
    always_comb begin
        reach = '1;
        if (standby) begin
            reach = '0;
            reach[SRC_ALM] = 1'b1;
        end
    end

    assign flags     = pend;
    assign tmr_value = tv_s;
    assign irq_n     = ~(|(pend & src_enable & reach));

endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic [6:0]  cur_hsec,
    input logic        tmr_run,
    input logic        tmr_clear,
    input logic        tmr_load,
    input logic [2:0]  src_enable,
    input logic [2:0]  flag_clear,
    input logic        standby,
    input logic [2:0]  flags,
    input logic [23:0] tmr_value,
    input logic        irq_n
);

    localparam logic [23:0] SPAN_END = {5'd23, 6'd59, 6'd59, 7'd99};

    AST_PER_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> $past(tick)) else $error("periodic flag without tick"); // R2

    AST_ALM_AT_WHOLE_SEC: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> ($past(tick) && ($past(cur_hsec) == 7'd0))) else $error("alarm off second"); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((($past(flags) & ~$past(flag_clear)) & ~flags) == 3'b000)) else $error("flag lost"); // R4

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> ((flags & src_enable) != 3'b000)) else $error("irq with nothing pending"); // R5

    AST_STANDBY_ALARM_ONLY: assert property (@(posedge clk) disable iff (rst)
        (standby && !(flags[1] && src_enable[1])) |-> irq_n) else $error("standby leak"); // R6

    AST_TMR_END_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> (tmr_value == SPAN_END)) else $error("timer flag off end"); // R8

    AST_TMR_HOLD_END: assert property (@(posedge clk) disable iff (rst)
        ((tmr_value == SPAN_END) && !tmr_clear && !tmr_load) |=> (tmr_value == SPAN_END)) else $error("timer moved past end"); // R8

    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tmr_run && !tmr_clear && !tmr_load) |=> $stable(tmr_value)) else $error("idle timer moved"); // R10

endmodule

bind rtc_irq_unit rtc_irq_unit_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .cur_hsec   (cur_hsec),
    .tmr_run    (tmr_run),
    .tmr_clear  (tmr_clear),
    .tmr_load   (tmr_load),
    .src_enable (src_enable),
    .flag_clear (flag_clear),
    .standby    (standby),
    .flags      (flags),
    .tmr_value  (tmr_value),
    .irq_n      (irq_n)
);

// File: tb/rtc_irq_unit_tb_top.sv
`timescale 1ns/1ps
module rtc_irq_unit_tb_top;

    localparam int SPAN_MAX = 8639999;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  per_rate = 2'd0;
    logic [6:0]  cur_hsec = '0;
    logic [5:0]  cur_sec = '0;
    logic [5:0]  cur_min = '0;
    logic [4:0]  cur_hour = '0;
    logic [4:0]  cur_day = '0;
    logic [5:0]  alm_sec = '0;
    logic [5:0]  alm_min = '0;
    logic [4:0]  alm_hour = '0;
    logic [4:0]  alm_day = '0;
    logic [3:0]  alm_ignore = '0;
    logic        tmr_run = 1'b0;
    logic        tmr_clear = 1'b0;
    logic        tmr_load = 1'b0;
    logic [23:0] tmr_load_val = '0;
    logic [2:0]  src_enable = '0;
    logic [2:0]  flag_clear = '0;
    logic        standby = 1'b0;
    logic [2:0]  flags;
    logic [23:0] tmr_value;
    logic        irq_n;

    int          n_checks = 0;
    int          n_fails = 0;

    int          m_ticks;
    logic [2:0]  m_flags;
    int          m_time;

    always #5 clk = ~clk;

    rtc_irq_unit dut_i (
        .clk (clk), .rst (rst), .tick (tick), .per_rate (per_rate),
        .cur_hsec (cur_hsec), .cur_sec (cur_sec), .cur_min (cur_min),
        .cur_hour (cur_hour), .cur_day (cur_day),
        .alm_sec (alm_sec), .alm_min (alm_min), .alm_hour (alm_hour),
        .alm_day (alm_day), .alm_ignore (alm_ignore),
        .tmr_run (tmr_run), .tmr_clear (tmr_clear), .tmr_load (tmr_load),
        .tmr_load_val (tmr_load_val), .src_enable (src_enable),
        .flag_clear (flag_clear), .standby (standby),
        .flags (flags), .tmr_value (tmr_value), .irq_n (irq_n)
    );

    function automatic int period_of(logic [1:0] r);
        case (r)
            2'd0:    return 1;
            2'd1:    return 10;
            2'd2:    return 100;
            default: return 6000;
        endcase
    endfunction

    function automatic logic [23:0] pack_cs(int t);
        logic [4:0] h;
        logic [5:0] m;
        logic [5:0] s;
        logic [6:0] c;
        c = 7'(t % 100);
        s = 6'((t / 100) % 60);
        m = 6'((t / 6000) % 60);
        h = 5'(t / 360000);
        return {h, m, s, c};
    endfunction

    function automatic int unpack_cs(logic [23:0] v);
        return int'(v[23:19]) * 360000 + int'(v[18:13]) * 6000 + int'(v[12:7]) * 100 + int'(v[6:0]);
    endfunction

    function automatic logic exp_irq_n(logic [2:0] f, logic [2:0] en, logic sb);
        logic [2:0] allow;
        allow = sb ? 3'b010 : 3'b111;
        return !(|(f & en & allow));
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(flags[0] == m_flags[0], "R2", "periodic flag", flags[0], m_flags[0]);
        check(flags[1] == m_flags[1], "R3", "alarm flag", flags[1], m_flags[1]);
        check(flags[2] == m_flags[2], "R8", "timer flag", flags[2], m_flags[2]);
        check(tmr_value == pack_cs(m_time), "R7", "timer value", tmr_value, pack_cs(m_time));
        if (standby)
            check(irq_n == exp_irq_n(m_flags, src_enable, 1'b1), "R6", "irq in standby",
                  irq_n, exp_irq_n(m_flags, src_enable, 1'b1));
        else
            check(irq_n == exp_irq_n(m_flags, src_enable, 1'b0), "R5", "irq",
                  irq_n, exp_irq_n(m_flags, src_enable, 1'b0));
    endtask

    // One clock: predict from the present inputs, take the edge, compare.
    task automatic step();
        logic per_ev;
        logic alm_ev;
        logic tmr_ev;
        int   nt;
        per_ev = tick && (((m_ticks + 1) % period_of(per_rate)) == 0);
        alm_ev = tick && (cur_hsec == 0) &&
                 (alm_ignore[0] || cur_sec == alm_sec) &&
                 (alm_ignore[1] || cur_min == alm_min) &&
                 (alm_ignore[2] || cur_hour == alm_hour) &&
                 (alm_ignore[3] || cur_day == alm_day);
        tmr_ev = 1'b0;
        nt = m_time;
        if (tmr_clear) nt = 0;
        else if (tmr_load) nt = unpack_cs(tmr_load_val);
        else if (tmr_run && tick && m_time != SPAN_MAX) begin
            nt = m_time + 1;
            tmr_ev = (nt == SPAN_MAX);
        end
        @(posedge clk);
        #2;
        if (tick) m_ticks = (m_ticks + 1) % 6000;
        m_flags = (m_flags & ~flag_clear) | {tmr_ev, alm_ev, per_ev};
        m_time = nt;
        compare_all();
    endtask

    task automatic quiet_inputs();
        tick = 1'b0; tmr_run = 1'b0; tmr_clear = 1'b0; tmr_load = 1'b0;
        flag_clear = 3'b000; standby = 1'b0;
    endtask

    task automatic rand_inputs();
        tick       = ($urandom % 8) != 0;
        cur_hsec   = ($urandom % 3 == 0) ? 7'd0 : 7'($urandom % 100);
        cur_sec    = ($urandom % 2 == 0) ? alm_sec : 6'($urandom % 60);
        cur_min    = ($urandom % 4 != 0) ? alm_min : 6'($urandom % 60);
        cur_hour   = ($urandom % 4 != 0) ? alm_hour : 5'($urandom % 24);
        cur_day    = ($urandom % 4 != 0) ? alm_day : 5'(1 + $urandom % 31);
        if ($urandom % 500 == 0) per_rate = 2'($urandom);
        if ($urandom % 300 == 0) alm_ignore = 4'($urandom);
        tmr_run    = ($urandom % 6) != 0;
        tmr_clear  = ($urandom % 400) == 0;
        tmr_load   = ($urandom % 300) == 0;
        tmr_load_val = pack_cs(($urandom % 2 == 0) ? SPAN_MAX - int'($urandom % 50)
                                                   : int'($urandom % SPAN_MAX));
        src_enable = 3'($urandom);
        flag_clear = 3'($urandom) & 3'($urandom);
        if ($urandom % 200 == 0) standby = ~standby;
    endtask

    initial begin
        #(10 * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int per_hits;
        void'($urandom(32'd20240611));
        m_ticks = 0; m_flags = 3'b000; m_time = 0;
        tick = 1'b1; tmr_run = 1'b1; src_enable = 3'b111;
        repeat (4) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1: reset state, even with tick and run held high during reset
        check(flags == 3'b000, "R1", "flags after reset", flags, 0);
        check(tmr_value == 24'd0, "R1", "timer after reset", tmr_value, 0);
        check(irq_n == 1'b1, "R1", "irq after reset", irq_n, 1);
        quiet_inputs();

        // R2: minute rate gives one event in 6000 ticks, landing on the last one
        per_rate = 2'd3; src_enable = 3'b001; alm_ignore = 4'b0000;
        alm_day = 5'd9; cur_day = 5'd1; tick = 1'b1;
        per_hits = 0;
        for (int i = 0; i < 6000; i++) begin
            flag_clear = 3'b001;
            step();
            if (flags[0]) per_hits++;
        end
        check(per_hits == 1, "R2", "minute events in 6000 ticks", per_hits, 1);
        check(flags[0] == 1'b1, "R2", "minute event on tick 6000", flags[0], 1);

        // R4: clear strobe in the same cycle as an event keeps the flag set
        per_rate = 2'd0; flag_clear = 3'b001; tick = 1'b1;
        step();
        check(flags[0] == 1'b1, "R4", "set beats clear", flags[0], 1);
        tick = 1'b0;
        step();
        check(flags[0] == 1'b0, "R4", "clear without event", flags[0], 0);
        flag_clear = 3'b000;
        step();
        check(flags[0] == 1'b0, "R4", "stays clear", flags[0], 0);

        // R9 / R8: load near the end, count into it, then hold
        tmr_load_val = pack_cs(SPAN_MAX - 5); tmr_load = 1'b1; tick = 1'b1; tmr_run = 1'b1;
        step();
        check(tmr_value == pack_cs(SPAN_MAX - 5), "R9", "load value", tmr_value, pack_cs(SPAN_MAX - 5));
        check(flags[2] == 1'b0, "R9", "load sets no flag", flags[2], 0);
        tmr_load = 1'b0; src_enable = 3'b100; per_rate = 2'd2;
        repeat (5) step();
        check(tmr_value == pack_cs(SPAN_MAX), "R8", "reached end", tmr_value, pack_cs(SPAN_MAX));
        check(flags[2] == 1'b1, "R8", "end flag", flags[2], 1);
        check(irq_n == 1'b0, "R5", "timer irq", irq_n, 0);
        repeat (20) step();
        check(tmr_value == pack_cs(SPAN_MAX), "R8", "held at end", tmr_value, pack_cs(SPAN_MAX));

        // R6: timer flag pending but hidden in standby
        standby = 1'b1;
        step();
        check(irq_n == 1'b1, "R6", "timer masked in standby", irq_n, 1);

        // R3: alarm at whole second matches, raises irq in standby
        src_enable = 3'b110; alm_sec = 6'd30; alm_min = 6'd15; alm_hour = 5'd7; alm_day = 5'd12;
        cur_sec = 6'd30; cur_min = 6'd15; cur_hour = 5'd7; cur_day = 5'd12; cur_hsec = 7'd0;
        tick = 1'b1; tmr_run = 1'b0;
        step();
        check(flags[1] == 1'b1, "R3", "full alarm match", flags[1], 1);
        check(irq_n == 1'b0, "R6", "alarm drives irq in standby", irq_n, 0);
        flag_clear = 3'b010; tick = 1'b0;
        step();
        flag_clear = 3'b000; cur_day = 5'd13; tick = 1'b1;
        step();
        check(flags[1] == 1'b0, "R3", "day mismatch blocks alarm", flags[1], 0);
        alm_ignore = 4'b1000;
        step();
        check(flags[1] == 1'b1, "R3", "day ignored", flags[1], 1);
        standby = 1'b0;

        // R10 / R9: idle hold, then clear beats load
        tmr_run = 1'b0; tick = 1'b1;
        repeat (3) step();
        check(tmr_value == pack_cs(SPAN_MAX), "R10", "idle timer holds", tmr_value, pack_cs(SPAN_MAX));
        tmr_clear = 1'b1; tmr_load = 1'b1; tmr_load_val = pack_cs(12345);
        step();
        check(tmr_value == 24'd0, "R9", "clear over load", tmr_value, 0);
        tmr_clear = 1'b0; tmr_load = 1'b0; tmr_run = 1'b1;
        repeat (250) step();
        check(tmr_value == pack_cs(250), "R7", "carry into seconds", tmr_value, pack_cs(250));

        // Constrained random phase, compared every cycle
        alm_ignore = 4'b0000;
        for (int i = 0; i < 20000; i++) begin
            rand_inputs();
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule